// File: doc/BRIEF.md
# I2C Two-Byte Control Word Receiver

This block is a receive-only I2C target that fills a 16-bit control word from a single write transfer on the bus. The system clock samples the SCL and SDA lines, which arrive from pads, and passes them through two-flop synchronisers. START, STOP and SCL edges are found on the synchronised samples. When the block acknowledges, it asks the pad to pull SDA low through an open-drain enable.

The target answers to one of two 7-bit addresses. The upper six bits are fixed at `001011`. The lowest bit is the inverse of a strap pin. A transfer that addresses this target with the write direction is acknowledged. The first data byte after it goes into the upper half of the control word and the second data byte into the lower half. Each half is updated at the moment its byte is acknowledged, so a transfer that stops after one byte still changes the upper half. Reads, clock stretching, general call and auto-increment beyond two bytes are not handled.

Top module: `i2c_ctl_word_slave`

## Requirements
- R1: After a synchronous active-low reset, the control word is 0x0000 and the SDA pull-down is released.
- R2: A START is SDA falling while SCL is high, and it begins address reception. A STOP is SDA rising while SCL is high, and it returns the target to idle with the pull-down released. SCL edges while idle have no effect.
- R3: The first byte after START carries seven address bits, MSB first, followed by a direction bit in which 0 means write. The target acknowledges only when the address equals {001011, NOT addr_pin_i} and the direction bit is 0. With the strap low the address is 0x17; with the strap high it is 0x16.
- R4: When the address does not match or the direction bit is 1, the target does not acknowledge any byte and leaves the control word unchanged until the next START or STOP.
- R5: In an acknowledged slot the pull-down is asserted throughout the high phase of the ninth SCL clock of the byte. It is released after that clock's falling edge. It is never asserted during the high phase of any of the eight data clocks.
- R6: The first data byte after an acknowledged address, received MSB first, is written to control word bits [15:8] when it is acknowledged.
- R7: The second data byte is written to control word bits [7:0] when it is acknowledged.
- R8: Bytes after the second data byte in the same transfer are not acknowledged and do not change the control word.
- R9: A repeated START at any bit position abandons the current transfer and restarts address reception. Halves already written are kept.
- R10: A STOP after only the first data byte leaves the new upper half and the old lower half in the control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL level from the pad |
| sda_i | input | 1 | SDA level from the pad (wired-AND bus value) |
| addr_pin_i | input | 1 | Strap pin; its inverse is the address LSB; assumed static |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain enable) |
| ctrl_word_o | output | 16 | Control word: [15:8] first data byte, [7:0] second data byte |

## Verification
The hardest case to reach from the ports is a repeated START that arrives partway through a data byte. The target must then discard the partial shift, keep the half it has already written, and treat the next byte as an address again. The bench drives the bus bit by bit, so it can stop a byte after any number of bits, raise SDA while SCL is low and issue a START. It then sends a fresh frame to a different half-state. A reference model in the bench tracks the expected pull-down and control word. The outputs are compared with it on every system clock during each SCL high phase, which covers the acknowledge windows and the data clocks between them.

// File: rtl/i2c_wr_pkg.sv
// Package: shared widths, fixed address bits and the frame state type
// for the I2C two-byte control word receiver.
package i2c_wr_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int CNT_W    = $clog2(BYTE_W + 1);

    // Upper six address bits; the LSB comes from the strap pin.
    localparam logic [ADDR_W-2:0] FIXED_ADDR_HI = 6'b001011;

    // Frame position of the receiver.
    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for START
        ST_ADDR,      // shifting address + direction
        ST_ACK_ADDR,  // acknowledging the address
        ST_HI,        // shifting first data byte
        ST_ACK_HI,    // acknowledging first data byte
        ST_LO,        // shifting second data byte
        ST_ACK_LO,    // acknowledging second data byte
        ST_SKIP       // not addressed / surplus bytes: stay quiet
    } wr_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings one asynchronous bus line into the clk domain through a chain of
// STAGES flops, and also provides the previous synchronised sample so that
// edge and condition detection can compare two consecutive samples.
// Assumes an idle bus line is high; all flops reset to 1.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic sync_o,
    output logic prev_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        genvar g;
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the raw pad level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= line_i;
                end
            end else begin : g_next
                // Later stages: settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Hold last synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = prev_q;

endmodule

// File: rtl/i2c_bus_events.sv
// Module: i2c_bus_events
// Turns current and previous synchronised SCL/SDA samples into single-cycle
// event strobes: START, STOP, SCL rising and SCL falling.
// Assumes both inputs pairs come from i2c_line_sync with equal latency.
module i2c_bus_events (
    input  logic scl_s,
    input  logic scl_p,
    input  logic sda_s,
    input  logic sda_p,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);

    logic scl_held_high;

    // Decode bus conditions from two consecutive samples.
    always_comb begin
        scl_held_high = scl_s & scl_p;
        start_o       = scl_held_high & sda_p & ~sda_s;
        stop_o        = scl_held_high & ~sda_p & sda_s;
        scl_rise_o    = ~scl_p & scl_s;
        scl_fall_o    = scl_p & ~scl_s;
    end

endmodule

// File: rtl/i2c_wr_fsm.sv
// Module: i2c_wr_fsm
// Frame engine: shifts bits on SCL rising edges, decides acknowledge at the
// SCL falling edge that ends the eighth bit, holds the pull-down through the
// ninth clock and releases it on that clock's falling edge. Data halves are
// written when their acknowledge is asserted.
// Assumes addr_sel is static (strap) and events come from i2c_bus_events.
module i2c_wr_fsm
    import i2c_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              scl_s_i,
    input  logic              sda_s_i,
    input  logic              addr_sel_i,
    output logic              pull_o,
    output logic [WORD_W-1:0] word_o
);

    wr_state_t          state_q;
    logic [CNT_W-1:0]   bit_cnt_q;
    logic [BYTE_W-1:0]  shreg_q;
    logic               pull_q;
    logic [WORD_W-1:0]  word_q;

    logic [ADDR_W-1:0]  own_addr;
    logic               byte_full;
    logic               shifting;
    logic               addr_hit;

    // Address compare and byte completion flags.
    always_comb begin
        own_addr  = {FIXED_ADDR_HI, ~addr_sel_i};
        byte_full = (bit_cnt_q == CNT_W'(BYTE_W));
        shifting  = (state_q == ST_ADDR) || (state_q == ST_HI) ||
                    (state_q == ST_LO);
        addr_hit  = (shreg_q[BYTE_W-1:1] == own_addr) && (shreg_q[0] == 1'b0);
    end

    // Frame sequencing, shifting, acknowledge drive and data writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            pull_q    <= 1'b0;
            word_q    <= '0;
        end else if (start_i) begin
            state_q   <= ST_ADDR;
            bit_cnt_q <= '0;
            pull_q    <= 1'b0;
        end else if (stop_i) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            pull_q    <= 1'b0;
        end else begin
            if (scl_rise_i && shifting && !byte_full) begin
                shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s_i};
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
            if (scl_fall_i) begin
                unique case (state_q)
                    ST_ADDR: if (byte_full) begin
                        bit_cnt_q <= '0;
                        if (addr_hit) begin
                            pull_q  <= 1'b1;
                            state_q <= ST_ACK_ADDR;
                        end else begin
                            state_q <= ST_SKIP;
                        end
                    end
                    ST_HI: if (byte_full) begin
                        bit_cnt_q                     <= '0;
                        pull_q                        <= 1'b1;
                        word_q[WORD_W-1:BYTE_W]       <= shreg_q;
                        state_q                       <= ST_ACK_HI;
                    end
                    ST_LO: if (byte_full) begin
                        bit_cnt_q                     <= '0;
                        pull_q                        <= 1'b1;
                        word_q[BYTE_W-1:0]            <= shreg_q;
                        state_q                       <= ST_ACK_LO;
                    end
                    ST_ACK_ADDR: begin
                        pull_q  <= 1'b0;
                        state_q <= ST_HI;
                    end
                    ST_ACK_HI: begin
                        pull_q  <= 1'b0;
                        state_q <= ST_LO;
                    end
                    ST_ACK_LO: begin
                        pull_q  <= 1'b0;
                        state_q <= ST_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pull_o = pull_q;
    assign word_o = word_q;

    // R5: pull-down changes only after an SCL fall or a bus condition.
    assert_pull_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_q != $past(pull_q)) |-> $past(scl_fall_i || start_i || stop_i));

    // R5: pull-down never moves while SCL has been high for two samples.
    assert_pull_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s_i && $past(scl_s_i) && !$past(start_i) && !$past(stop_i))
        |-> $stable(pull_q));

    // R9: any START restarts address reception from bit zero.
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == ST_ADDR) && (bit_cnt_q == '0) && !pull_q);

    // R2: STOP returns to idle with SDA released.
    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (state_q == ST_IDLE) && !pull_q);

    // R6: control word changes only together with a fresh acknowledge.
    assert_word_at_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (word_q != $past(word_q)) |-> (pull_q && !$past(pull_q)));

    // R4: a skipped frame never drives SDA.
    assert_skip_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> !pull_q);

endmodule

// File: rtl/i2c_ctl_word_slave.sv
// Module: i2c_ctl_word_slave (top)
// Receive-only I2C target writing a 16-bit control word from a two-byte
// write transfer. Synchronises SCL/SDA, detects bus events, and runs the
// frame engine. sda_pull_o is an open-drain enable (1 = drive SDA low).
// Assumes clk oversamples SCL so each SCL phase spans several clk cycles.
module i2c_ctl_word_slave
    import i2c_wr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_pin_i,
    output logic              sda_pull_o,
    output logic [WORD_W-1:0] ctrl_word_o
);

    logic scl_s, scl_p, sda_s, sda_p;
    logic ev_start, ev_stop, ev_rise, ev_fall;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (scl_i),
        .sync_o (scl_s),
        .prev_o (scl_p)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (sda_i),
        .sync_o (sda_s),
        .prev_o (sda_p)
    );

    i2c_bus_events u_events (
        .scl_s      (scl_s),
        .scl_p      (scl_p),
        .sda_s      (sda_s),
        .sda_p      (sda_p),
        .start_o    (ev_start),
        .stop_o     (ev_stop),
        .scl_rise_o (ev_rise),
        .scl_fall_o (ev_fall)
    );

    i2c_wr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (ev_start),
        .stop_i     (ev_stop),
        .scl_rise_i (ev_rise),
        .scl_fall_i (ev_fall),
        .scl_s_i    (scl_s),
        .sda_s_i    (sda_s),
        .addr_sel_i (addr_pin_i),
        .pull_o     (sda_pull_o),
        .word_o     (ctrl_word_o)
    );

endmodule

// File: tb/sim_i2c_ctl_word_slave.sv
// Bench: drives the bus bit by bit as a master with an open-drain model,
// keeps a behavioural expectation of pull-down and control word, and
// compares them on every clock inside each SCL high phase.
module sim_i2c_ctl_word_slave;

    localparam int H = 8;            // clk cycles per SCL phase

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_drv = 1'b1;
    logic        sel = 1'b0;
    logic        pull;
    logic [15:0] word;
    logic        sda_line;

    int          checks = 0;
    int          failures = 0;
    logic        chk_en = 1'b0;
    logic        exp_pull = 1'b0;
    logic [15:0] exp_word = 16'h0000;
    string       cur_req = "R1";
    bit          done = 1'b0;

    assign sda_line = sda_drv & ~pull;

    always #5 clk = ~clk;

    i2c_ctl_word_slave u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .addr_pin_i  (sel),
        .sda_pull_o  (pull),
        .ctrl_word_o (word)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic check(input string req);
        checks++;
        if (pull !== exp_pull || word !== exp_word) begin
            failures++;
            $display("FAIL %s pull=%0b/%04h expected %0b/%04h at %0t",
                     req, pull, word, exp_pull, exp_word, $time);
        end
    endtask

    // Per-clock comparison against the reference during SCL high phases.
    always @(negedge clk) begin
        if (chk_en && rst_n) check(cur_req);
    end

    task automatic send_bit(input logic b, input logic ack_exp, input string req);
        tick(H/2);
        sda_drv = b;
        tick(H/2);
        scl = 1'b1;
        tick(4);
        exp_pull = ack_exp;
        cur_req  = req;
        chk_en   = 1'b1;
        tick(H-4);
        chk_en   = 1'b0;
        scl      = 1'b0;
        exp_pull = 1'b0;
    endtask

    // lane: 0 none, 1 upper half, 2 lower half written at the ack.
    task automatic send_byte(input logic [7:0] d, input logic ack_exp,
                             input int lane, input string req);
        for (int i = 7; i >= 0; i--) send_bit(d[i], 1'b0, req);
        if (ack_exp && lane == 1) exp_word[15:8] = d;
        if (ack_exp && lane == 2) exp_word[7:0]  = d;
        send_bit(1'b1, ack_exp, req);
    endtask

    task automatic do_start();
        scl = 1'b0;
        tick(H/2);
        sda_drv = 1'b1;
        tick(H/2);
        scl = 1'b1;
        tick(H);
        sda_drv = 1'b0;
        tick(H);
        scl = 1'b0;
    endtask

    task automatic do_stop(input string req);
        scl = 1'b0;
        tick(H/2);
        sda_drv = 1'b0;
        tick(H/2);
        scl = 1'b1;
        tick(H);
        sda_drv = 1'b1;
        tick(H);
        @(negedge clk);
        exp_pull = 1'b0;
        check(req);
    endtask

    function automatic logic addressed(input logic [6:0] a, input logic rw,
                                       input logic s);
        return (a == {6'b001011, ~s}) && (rw == 1'b0);
    endfunction

    // Full frame with up to three data bytes, expectation from R3/R6/R7/R8.
    task automatic frame(input logic [6:0] a, input logic rw, input int n,
                         input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input string req);
        logic hit;
        hit = addressed(a, rw, sel);
        do_start();
        send_byte({a, rw}, hit, 0, req);
        if (n > 0) send_byte(b0, hit, 1, hit ? "R6" : "R4");
        if (n > 1) send_byte(b1, hit, 2, hit ? "R7" : "R4");
        if (n > 2) send_byte(b2, 1'b0, 0, "R8");
        do_stop(req);
    endtask

    initial begin
        tick(4);
        @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        tick(4);
        @(negedge clk);
        check("R1");

        // R2: SCL toggles while idle have no effect.
        for (int i = 0; i < 3; i++) begin
            scl = 1'b0; tick(H); scl = 1'b1; tick(H);
            @(negedge clk); check("R2");
        end

        // R3/R6/R7: strap low, address 0x17.
        sel = 1'b0;
        frame(7'h17, 1'b0, 2, 8'hA5, 8'hC3, 8'h00, "R3");
        // R3: strap high, address 0x16.
        sel = 1'b1;
        frame(7'h16, 1'b0, 2, 8'h5A, 8'h3C, 8'h00, "R3");
        // R4: wrong address for strap high.
        frame(7'h17, 1'b0, 2, 8'hFF, 8'hEE, 8'h00, "R4");
        // R4: read direction is refused.
        frame(7'h16, 1'b1, 2, 8'h11, 8'h22, 8'h00, "R4");
        sel = 1'b0;
        frame(7'h16, 1'b0, 1, 8'h77, 8'h00, 8'h00, "R4");
        // R10: only upper half, then STOP.
        frame(7'h17, 1'b0, 1, 8'h81, 8'h00, 8'h00, "R10");
        // R8: surplus third byte.
        frame(7'h17, 1'b0, 3, 8'h12, 8'h34, 8'hFF, "R8");

        // R9: repeated START mid-way through the second data byte.
        do_start();
        send_byte({7'h17, 1'b0}, 1'b1, 0, "R9");
        send_byte(8'hDE, 1'b1, 1, "R9");
        for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0, "R9");
        do_start();
        send_byte({7'h17, 1'b0}, 1'b1, 0, "R9");
        send_byte(8'h4B, 1'b1, 1, "R9");
        // R9: repeated START right after an address ack.
        do_start();
        send_byte({7'h17, 1'b0}, 1'b1, 0, "R9");
        do_start();
        send_byte({7'h17, 1'b0}, 1'b1, 0, "R9");
        send_byte(8'h69, 1'b1, 1, "R9");
        send_byte(8'h96, 1'b1, 2, "R9");
        do_stop("R9");

        // R4: a not-addressed frame is left by a STOP; next frame works.
        frame(7'h00, 1'b0, 1, 8'hAA, 8'h00, 8'h00, "R4");
        frame(7'h17, 1'b0, 2, 8'h0F, 8'hF0, 8'h00, "R2");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule